// File: doc/BRIEF.md
# Radio serial register programmer

This block programs the configuration registers of an RF transceiver over a three-wire serial link (serial clock, serial data, latch enable). A host issues one command at a time: a direct register write, a channel change, a full power-up sequence, or a shutdown. The block builds each 16-bit frame, shifts it out bit by bit, and then commits it to the addressed register with one extra clock pulse while the enable line is high.

A channel number is turned into a synthesizer divider value by an internal lookup, and that value is written to the channel register. The power-up sequence writes six registers in a fixed order, and the channel register is one of them. `busy` is high while a command is running. `done` pulses once when the last frame of the command has settled. A channel outside the supported range is refused with an `err` pulse and sends no frame.

Top-level sequencer states are `Q_IDLE` (waiting for a command), `Q_LAUNCH` (hand one frame to the shifter) and `Q_WAIT` (wait for that frame to settle). `Q_IDLE→Q_LAUNCH` runs on an accepted command. `Q_LAUNCH→Q_WAIT` always happens. `Q_WAIT→Q_LAUNCH` runs when a frame ends and more frames remain, and `Q_WAIT→Q_IDLE` runs after the last frame. Shifter states are `SH_IDLE`, `SH_SETUP` (data driven, clock low), `SH_HIGH` (clock high), `SH_HOLD` (clock low), `LAT_SETUP` (enable high, clock low), `LAT_HIGH` (enable high, clock high) and `LAT_SETTLE` (enable high, clock low). They step `SH_IDLE→SH_SETUP→SH_HIGH→SH_HOLD`. From `SH_HOLD` the shifter goes back to `SH_SETUP` for the next bit, or to `LAT_SETUP` after bit 0. Then it steps `LAT_SETUP→LAT_HIGH→LAT_SETTLE→SH_IDLE`.

Top module: `rf_serial_prog`

## Requirements
- R1: A direct write (`cmd_op`=0) sends one frame equal to {`cmd_addr`[3:0], `cmd_data`[11:0]}. The frame has 16 bits, sent from bit 15 down to bit 0, and each bit is sampled on a rising edge of `rf_sclk` while `rf_sen` is low.
- R2: In each bit, `rf_sclk` is high for exactly CLK_DIV cycles. Between two consecutive rising edges of one frame, the clock is low for exactly 4×CLK_DIV cycles. `rf_sdata` never changes while `rf_sclk` is high.
- R3: After the 16th bit, `rf_sen` goes high for exactly (3+SETTLE_UNITS)×CLK_DIV cycles and carries exactly one `rf_sclk` rising edge.
- R4: Between commands, `rf_sclk` and `rf_sen` are low and `rf_sdata` keeps the value of the last bit sent. After reset all outputs are low.
- R5: A channel command (`cmd_op`=1) for channel n in 1..13 writes register 3 with 12+5×(n−1).
- R6: Channel 14 maps to 84 and channel 0 maps to 0, both written to register 3.
- R7: A power-up command (`cmd_op`=2, channel from `cmd_chan`) sends six frames in this order: reg0=0x007, reg1=0x01E, reg2=0x001, reg3=channel value, reg4=0x313, reg5=0x00F.
- R8: A shutdown command (`cmd_op`=3) sends one frame writing 0x000 to register 1.
- R9: `busy` rises in the cycle after a command is accepted. A command presented while `busy` is high is ignored and sends no frame.
- R10: `done` is a single-cycle pulse in the cycle after the last frame's settle interval ends, and `busy` falls in that same cycle. A multi-frame command gives exactly one pulse.
- R11: A channel or power-up command with `cmd_chan` above 14 makes `err` pulse for one cycle in the cycle after the request. No frame is sent and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | 0 write, 1 channel, 2 power-up, 3 shutdown |
| cmd_addr | input | 4 | Register address for a direct write |
| cmd_data | input | 12 | Register value for a direct write |
| cmd_chan | input | 5 | Channel number for channel and power-up commands |
| rf_sclk | output | 1 | Serial clock to the transceiver |
| rf_sdata | output | 1 | Serial data to the transceiver |
| rf_sen | output | 1 | Latch enable to the transceiver |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejected-channel pulse |

## Verification
Some properties are checked on every cycle. Data stays stable while the serial clock is high. The enable line is high only while busy. The link is quiet and the data line unchanged when idle. `done` lasts exactly one cycle, comes right as `busy` falls, and `err` never appears with `busy`. Other behaviour only the directed scenarios can show: the bit contents and order of each frame, the divider values from the lookup, the six-frame power-up order, the exact phase and enable durations, and that commands arriving while busy or with a bad channel send nothing.

// File: rtl/rfsp_pkg.sv
package rfsp_pkg;

    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 12;
    localparam int FRAME_W  = ADDR_W + DATA_W;
    localparam int CHAN_W   = 5;
    localparam int MAX_CHAN = 14;
    localparam int CH_BASE  = 12;
    localparam int CH_STEP  = 5;
    localparam int CH_TOP   = 84;
    localparam int INIT_LEN = 6;
    localparam int IDX_W    = $clog2(INIT_LEN);

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CHAN  = 2'd1,
        OP_INIT  = 2'd2,
        OP_SHUT  = 2'd3
    } op_e;

    function automatic logic [FRAME_W-1:0] pick_frame(
        input op_e                op,
        input logic [IDX_W-1:0]   idx,
        input logic [ADDR_W-1:0]  addr,
        input logic [DATA_W-1:0]  data,
        input logic [DATA_W-1:0]  divv
    );
        logic [FRAME_W-1:0] f;
        f = '0;
        case (op)
            OP_WRITE: f = {addr, data};
            OP_CHAN:  f = {4'd3, divv};
            OP_SHUT:  f = {4'd1, 12'h000};
            OP_INIT: begin
                case (idx)
                    3'd0:    f = {4'd0, 12'h007};
                    3'd1:    f = {4'd1, 12'h01E};
                    3'd2:    f = {4'd2, 12'h001};
                    3'd3:    f = {4'd3, divv};
                    3'd4:    f = {4'd4, 12'h313};
                    default: f = {4'd5, 12'h00F};
                endcase
            end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rfsp_chan_lut.sv
module rfsp_chan_lut
    import rfsp_pkg::*;
(
    input  logic [CHAN_W-1:0] chan,
    output logic [DATA_W-1:0] divv,
    output logic              chan_ok
);
    logic [DATA_W-1:0] stepped;

    assign stepped = DATA_W'(CH_BASE) + DATA_W'(CH_STEP) * (DATA_W'(chan) - DATA_W'(1));
    assign chan_ok = (chan <= CHAN_W'(MAX_CHAN));

    always_comb begin
        if (chan == '0)
            divv = '0;
        else if (chan < CHAN_W'(MAX_CHAN))
            divv = stepped;
        else if (chan == CHAN_W'(MAX_CHAN))
            divv = DATA_W'(CH_TOP);
        else
            divv = '0;
    end
endmodule

// File: rtl/rfsp_shifter.sv
module rfsp_shifter
    import rfsp_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int SETTLE_UNITS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               sclk,
    output logic               sdata,
    output logic               sen,
    output logic               fin
);
    localparam int LOW_CYC  = 2 * CLK_DIV;
    localparam int HIGH_CYC = CLK_DIV;
    localparam int SET_CYC  = SETTLE_UNITS * CLK_DIV;
    localparam int CNT_W    = $clog2(LOW_CYC + SET_CYC + 1);
    localparam int BIT_W    = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        SH_IDLE, SH_SETUP, SH_HIGH, SH_HOLD, LAT_SETUP, LAT_HIGH, LAT_SETTLE
    } sh_e;

    sh_e                st, nxt;
    logic [CNT_W-1:0]   cnt, reload;
    logic [BIT_W-1:0]   bitn;
    logic [FRAME_W-1:0] shreg;
    logic               expd;

    assign expd = (cnt == '0);

    always_comb begin
        nxt = st;
        unique case (st)
            SH_IDLE:    if (start) nxt = SH_SETUP;
            SH_SETUP:   if (expd)  nxt = SH_HIGH;
            SH_HIGH:    if (expd)  nxt = SH_HOLD;
            SH_HOLD:    if (expd)  nxt = (bitn == '0) ? LAT_SETUP : SH_SETUP;
            LAT_SETUP:  if (expd)  nxt = LAT_HIGH;
            LAT_HIGH:   if (expd)  nxt = LAT_SETTLE;
            LAT_SETTLE: if (expd)  nxt = SH_IDLE;
            default:               nxt = SH_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            SH_SETUP, SH_HOLD, LAT_SETUP: reload = CNT_W'(LOW_CYC - 1);
            SH_HIGH, LAT_HIGH:            reload = CNT_W'(HIGH_CYC - 1);
            LAT_SETTLE:                   reload = CNT_W'(SET_CYC - 1);
            default:                      reload = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= SH_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            st <= nxt;
            if (nxt != st)
                cnt <= reload;
            else if (!expd)
                cnt <= cnt - 1'b1;
            if (st == SH_IDLE && start) begin
                shreg <= frame;
                bitn  <= BIT_W'(FRAME_W - 1);
            end else if (st == SH_HOLD && expd && bitn != '0) begin
                shreg <= {shreg[FRAME_W-2:0], 1'b0};
                bitn  <= bitn - 1'b1;
            end
        end
    end

    always_comb begin
        sclk  = (st == SH_HIGH) || (st == LAT_HIGH);
        sen   = (st == LAT_SETUP) || (st == LAT_HIGH) || (st == LAT_SETTLE);
        sdata = shreg[FRAME_W-1];
        fin   = (st == LAT_SETTLE) && expd;
    end
endmodule

// File: rtl/rf_serial_prog.sv
module rf_serial_prog
    import rfsp_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int SETTLE_UNITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [CHAN_W-1:0] cmd_chan,
    output logic              rf_sclk,
    output logic              rf_sdata,
    output logic              rf_sen,
    output logic              busy,
    output logic              done,
    output logic              err
);
    typedef enum logic [1:0] {Q_IDLE, Q_LAUNCH, Q_WAIT} q_e;

    q_e                 st, nxt;
    op_e                op_q, op_in;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q, div_q, lut_div;
    logic [IDX_W-1:0]   idx_q, last_idx;
    logic               lut_ok, reject, accept, fin, last_hit;
    logic               done_q, err_q;
    logic [FRAME_W-1:0] frame;

    assign op_in    = op_e'(cmd_op);
    assign reject   = (op_in == OP_CHAN || op_in == OP_INIT) && !lut_ok;
    assign accept   = (st == Q_IDLE) && cmd_valid && !reject;
    assign last_idx = (op_q == OP_INIT) ? IDX_W'(INIT_LEN - 1) : '0;
    assign last_hit = (idx_q == last_idx);
    assign frame    = pick_frame(op_q, idx_q, addr_q, data_q, div_q);

    rfsp_chan_lut u_lut (
        .chan    (cmd_chan),
        .divv    (lut_div),
        .chan_ok (lut_ok)
    );

    rfsp_shifter #(
        .CLK_DIV      (CLK_DIV),
        .SETTLE_UNITS (SETTLE_UNITS)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st == Q_LAUNCH),
        .frame (frame),
        .sclk  (rf_sclk),
        .sdata (rf_sdata),
        .sen   (rf_sen),
        .fin   (fin)
    );

    always_comb begin
        nxt = st;
        unique case (st)
            Q_IDLE:   if (accept) nxt = Q_LAUNCH;
            Q_LAUNCH: nxt = Q_WAIT;
            Q_WAIT:   if (fin) nxt = last_hit ? Q_IDLE : Q_LAUNCH;
            default:  nxt = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= Q_IDLE;
            op_q   <= OP_WRITE;
            addr_q <= '0;
            data_q <= '0;
            div_q  <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st     <= nxt;
            done_q <= (st == Q_WAIT) && fin && last_hit;
            err_q  <= (st == Q_IDLE) && cmd_valid && reject;
            if (accept) begin
                op_q   <= op_in;
                addr_q <= cmd_addr;
                data_q <= cmd_data;
                div_q  <= lut_div;
                idx_q  <= '0;
            end else if (st == Q_WAIT && fin && !last_hit) begin
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy = (st != Q_IDLE);
        done = done_q;
        err  = err_q;
    end
endmodule

// File: rtl/rfsp_chk.sv
module rfsp_chk (
    input logic clk,
    input logic rst_n,
    input logic rf_sclk,
    input logic rf_sdata,
    input logic rf_sen,
    input logic busy,
    input logic done,
    input logic err
);
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rf_sclk |-> $stable(rf_sdata)); // R2
    AST_SEN_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_sen |-> busy); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rf_sclk && !rf_sen)); // R4
    AST_IDLE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(rf_sdata)); // R4
    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R11
endmodule

bind rf_serial_prog rfsp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rf_sclk  (rf_sclk),
    .rf_sdata (rf_sdata),
    .rf_sen   (rf_sen),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/sim_rf_serial_prog.sv
`timescale 1ns/1ps
module sim_rf_serial_prog;
    localparam int DIV = 2;
    localparam int SET = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_addr = 4'd0;
    logic [11:0] cmd_data = 12'd0;
    logic [4:0]  cmd_chan = 5'd0;
    logic        rf_sclk, rf_sdata, rf_sen, busy, done, err;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rf_serial_prog #(.CLK_DIV(DIV), .SETTLE_UNITS(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_chan(cmd_chan),
        .rf_sclk(rf_sclk), .rf_sdata(rf_sdata), .rf_sen(rf_sen),
        .busy(busy), .done(done), .err(err)
    );

    // frame capture on serial clock rising edges
    logic [15:0] flog [0:15];
    int          fbits [0:15];
    int          fcnt = 0;
    logic [15:0] cur = '0;
    int          nb = 0;
    int          lat_rises = 0;

    always @(posedge rf_sclk) begin
        if (!rf_sen) begin
            cur = {cur[14:0], rf_sdata};
            nb++;
        end else begin
            lat_rises++;
            if (fcnt < 16) begin
                flog[fcnt]  = cur;
                fbits[fcnt] = nb;
            end
            fcnt++;
            nb = 0;
        end
    end

    // phase timing monitor
    int  hirun = 0, lorun = 0, hibad = 0, lobad = 0, chg_hi = 0;
    int  senrun = 0, senlen = 0, done_cnt = 0;
    bit  seen_rise = 1'b0, prev_sclk = 1'b0, prev_sdata = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_sclk && prev_sclk && rf_sdata != prev_sdata) chg_hi++;
            if (rf_sclk) begin
                if (!prev_sclk) begin
                    if (seen_rise && lorun != 4 * DIV) lobad++;
                    seen_rise = 1'b1;
                end
                hirun++;
                lorun = 0;
            end else begin
                if (hirun != 0 && hirun != DIV) hibad++;
                hirun = 0;
                lorun++;
            end
            if (!busy) seen_rise = 1'b0;
            if (rf_sen) senrun++;
            else if (senrun != 0) begin senlen = senrun; senrun = 0; end
            if (done) done_cnt++;
            prev_sclk  = rf_sclk;
            prev_sdata = rf_sdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        fcnt = 0; nb = 0; lat_rises = 0; hibad = 0; lobad = 0; chg_hi = 0;
        done_cnt = 0; senlen = 0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] a,
                         input logic [11:0] d, input logic [4:0] ch);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_chan = ch;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done, req, done, 1);
        @(negedge clk);
        chk(!done && !busy, {req, " done single pulse"}, done, 0);
    endtask

    task automatic t_reset();
        chk(!rf_sclk && !rf_sen && !rf_sdata, "R4 reset outputs",
            {rf_sclk, rf_sen, rf_sdata}, 0);
        chk(!busy && !done && !err, "R4 reset status", {busy, done, err}, 0);
    endtask

    task automatic t_write();
        clear_log();
        issue(2'd0, 4'hA, 12'h5C3, 5'd0);
        chk(busy, "R9 busy after accept", busy, 1);
        issue(2'd0, 4'h1, 12'hFFF, 5'd0);
        wait_done("R10 write done");
        chk(fcnt == 1, "R9 command while busy ignored", fcnt, 1);
        chk(flog[0] == 16'hA5C3, "R1 frame content", flog[0], 16'hA5C3);
        chk(fbits[0] == 16, "R1 bit count", fbits[0], 16);
        chk(hibad == 0 && lobad == 0, "R2 phase lengths", hibad + lobad, 0);
        chk(chg_hi == 0, "R2 data stable while clock high", chg_hi, 0);
        chk(senlen == (3 + SET) * DIV, "R3 enable length", senlen, (3 + SET) * DIV);
        chk(lat_rises == 1, "R3 one latch pulse", lat_rises, 1);
        chk(done_cnt == 1, "R10 one done", done_cnt, 1);
        repeat (20) @(negedge clk);
        chk(rf_sdata == 1'b1 && !rf_sclk && !rf_sen, "R4 idle holds last bit",
            {rf_sdata, rf_sclk, rf_sen}, 3'b100);
    endtask

    task automatic t_chan(input logic [4:0] ch, input logic [15:0] exp, input string req);
        clear_log();
        issue(2'd1, 4'h0, 12'h000, ch);
        wait_done(req);
        chk(fcnt == 1 && flog[0] == exp, req, flog[0], exp);
    endtask

    task automatic t_bad(input logic [1:0] op, input string req);
        clear_log();
        issue(op, 4'h0, 12'h000, 5'd15);
        chk(err && !busy, {req, " err pulse"}, {err, busy}, 2'b10);
        @(negedge clk);
        chk(!err, {req, " err single"}, err, 0);
        repeat (60) @(negedge clk);
        chk(fcnt == 0 && !busy && done_cnt == 0, {req, " no frame"}, fcnt, 0);
    endtask

    task automatic t_init();
        logic [15:0] exp [0:5];
        exp[0] = 16'h0007; exp[1] = 16'h101E; exp[2] = 16'h2001;
        exp[3] = 16'h3025; exp[4] = 16'h4313; exp[5] = 16'h500F;
        clear_log();
        issue(2'd2, 4'h0, 12'h000, 5'd6);
        wait_done("R10 init done");
        chk(fcnt == 6, "R7 init frame count", fcnt, 6);
        for (int i = 0; i < 6; i++)
            chk(flog[i] == exp[i], "R7 init frame order", flog[i], exp[i]);
        chk(done_cnt == 1, "R10 single done for sequence", done_cnt, 1);
    endtask

    task automatic t_shut();
        clear_log();
        issue(2'd3, 4'hF, 12'hABC, 5'd0);
        wait_done("R8 shutdown done");
        chk(fcnt == 1 && flog[0] == 16'h1000, "R8 shutdown frame", flog[0], 16'h1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write();
        t_chan(5'd1,  16'h300C, "R5 channel 1");
        t_chan(5'd7,  16'h302A, "R5 channel 7");
        t_chan(5'd13, 16'h3048, "R5 channel 13");
        t_chan(5'd14, 16'h3054, "R6 channel 14");
        t_chan(5'd0,  16'h3000, "R6 channel 0");
        t_bad(2'd1, "R11 channel 15");
        t_bad(2'd2, "R11 init channel 15");
        t_init();
        t_shut();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule